// File: doc/BRIEF.md
# Next-PC Redirect and Load-Use Stall Unit

This unit picks the next program counter for a five-stage pipeline and produces the control bits that cancel or hold instructions in the front stages. Conditional branches resolve late, from the register between the execute and memory stages, under a predict-not-taken policy. A taken branch steers the PC to its target and turns the instruction in the fetch/decode register into a nop. Unconditional jumps resolve earlier, from the decode/execute register. They redirect the PC without a flush, so the instruction after the jump executes as a delay slot.

A load followed at once by a consumer of its destination register holds the PC and the fetch/decode register for one cycle and sends a bubble into the execute stage. The unit also contains the adder that forms a branch target from the incremented PC and the immediate. It keeps a free-running cycle counter and a count of fetches that are allowed to retire.

Top module: `pc_redirect_unit`

## Requirements
- R1: With the late branch bit set, the sense bit clear and an ALU result of zero, the branch is taken: next_pc_o equals the late branch target, pc_sel_o is 1 and ifid_flush_o is 1.
- R2: With the late branch bit and the sense bit both set, the branch is taken exactly when the ALU result is non-zero.
- R3: Without a taken branch, a jump or a stall, next_pc_o is pc_i + 4, pc_sel_o is 0 and ifid_flush_o is 0.
- R4: br_target_o equals idex_pc4_i plus the sign-extended 16-bit immediate shifted left by two, with wrap-around modulo 2^32.
- R5: With the jump bit set, next_pc_o equals idex_jump_target_i, pc_sel_o is 2, and the jump by itself does not raise ifid_flush_o.
- R6: When a jump and a taken branch occur in the same cycle, the jump target wins on next_pc_o and pc_sel_o is 2, while ifid_flush_o stays 1.
- R7: When idex_mem_read_i is set and ifid_rs_i or ifid_rt_i equals idex_rt_i, stall_o and idex_bubble_o are 1, next_pc_o equals pc_i and pc_sel_o is 3.
- R8: A load-use match raises neither stall_o nor idex_bubble_o in a cycle that has a taken branch or a jump.
- R9: cycle_cnt_o is 0 during reset and rises by one on every clock edge after reset.
- R10: retired_cnt_o is 0 during reset. On each clock edge it rises by one, except that it stays unchanged when stall_o or ifid_flush_o was high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current fetch PC |
| exm_branch_i | input | 1 | Late stage holds a conditional branch |
| exm_br_ne_i | input | 1 | Branch sense: 1 = taken on non-zero result |
| exm_alu_res_i | input | 32 | Comparison result of the late branch |
| exm_br_target_i | input | 32 | Registered target of the late branch |
| idex_pc4_i | input | 32 | Incremented PC of the instruction in execute |
| idex_imm_i | input | 16 | Immediate of the instruction in execute |
| idex_jump_i | input | 1 | Execute-stage instruction is a jump |
| idex_jump_target_i | input | 32 | Jump destination |
| idex_mem_read_i | input | 1 | Execute-stage instruction is a load |
| idex_rt_i | input | 5 | Destination register of that load |
| ifid_rs_i | input | 5 | First source field of the decoding instruction |
| ifid_rt_i | input | 5 | Second source field of the decoding instruction |
| br_target_o | output | 32 | Branch target from the adder, to be registered downstream |
| next_pc_o | output | 32 | PC to load at the next edge |
| pc_sel_o | output | 2 | 0 sequential, 1 branch, 2 jump, 3 hold |
| ifid_flush_o | output | 1 | Replace the fetch/decode instruction with a nop |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| idex_bubble_o | output | 1 | Insert a nop into the decode/execute register |
| cycle_cnt_o | output | 32 | Elapsed cycles |
| retired_cnt_o | output | 32 | Fetches allowed to proceed |

## Verification
The redirect choice, the flush, the stall, the bubble and the branch target come from combinational logic on the inputs of the same cycle. The bench drives each vector just after a falling edge and compares these outputs a few nanoseconds later, before the next rising edge. Both counters take their new value on the rising edge that ends the cycle. The bench therefore advances its own model at that edge and compares the counters one nanosecond after it. That comparison uses the stall and flush values it predicted for the vector just applied.

// File: rtl/pru_pkg.sv
package pru_pkg;
  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_BRANCH = 2'd1,
    PC_JUMP   = 2'd2,
    PC_HOLD   = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/pru_branch_target.sv
module pru_branch_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc4_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offset;

  assign offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = pc4_i + offset;
endmodule

// File: rtl/pru_branch_eval.sv
module pru_branch_eval #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            branch_i,
  input  logic            sense_ne_i,
  input  logic [XLEN-1:0] alu_res_i,
  output logic            taken_o
);
  logic res_zero;

  assign res_zero = (alu_res_i == '0);
  assign taken_o  = branch_i & (sense_ne_i ? ~res_zero : res_zero);

  // R1: equality branch with zero difference is taken
  a_r1_eq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && !sense_ne_i && alu_res_i == '0) |-> taken_o);

  // R2: inequality branch follows a non-zero result
  a_r2_ne_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && sense_ne_i) |-> (taken_o == (alu_res_i != '0)));
endmodule

// File: rtl/pru_load_use.sv
module pru_load_use #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     mem_read_i,
  input  logic [AW-1:0]            load_rt_i,
  input  logic [NSRC-1:0][AW-1:0]  src_i,
  output logic                     hazard_o
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = (src_i[g] == load_rt_i);
  end

  assign hazard_o = mem_read_i & (|hit);
endmodule

// File: rtl/pru_counters.sv
module pru_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             flush_i,
  output logic [CNT_W-1:0] cycle_cnt_o,
  output logic [CNT_W-1:0] retired_cnt_o
);
  logic advance;

  assign advance = ~stall_i & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_cnt_o   <= '0;
      retired_cnt_o <= '0;
    end else begin
      cycle_cnt_o   <= cycle_cnt_o + 1'b1;
      retired_cnt_o <= retired_cnt_o + CNT_W'(advance);
    end
  end

  a_r9_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cycle_cnt_o == $past(cycle_cnt_o) + 1'b1));

  a_r10_hold_on_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i || flush_i) |=> (retired_cnt_o == $past(retired_cnt_o)));
endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int AW    = 5,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             exm_branch_i,
  input  logic             exm_br_ne_i,
  input  logic [XLEN-1:0]  exm_alu_res_i,
  input  logic [XLEN-1:0]  exm_br_target_i,
  input  logic [XLEN-1:0]  idex_pc4_i,
  input  logic [IMM_W-1:0] idex_imm_i,
  input  logic             idex_jump_i,
  input  logic [XLEN-1:0]  idex_jump_target_i,
  input  logic             idex_mem_read_i,
  input  logic [AW-1:0]    idex_rt_i,
  input  logic [AW-1:0]    ifid_rs_i,
  input  logic [AW-1:0]    ifid_rt_i,
  output logic [XLEN-1:0]  br_target_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [1:0]       pc_sel_o,
  output logic             ifid_flush_o,
  output logic             stall_o,
  output logic             idex_bubble_o,
  output logic [CNT_W-1:0] cycle_cnt_o,
  output logic [CNT_W-1:0] retired_cnt_o
);
  import pru_pkg::*;

  localparam int NSRC = 2;
  localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

  logic                   br_taken;
  logic                   hazard;
  logic [NSRC-1:0][AW-1:0] srcs;
  pc_sel_e                sel;

  pru_branch_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
    .pc4_i    (idex_pc4_i),
    .imm_i    (idex_imm_i),
    .target_o (br_target_o)
  );

  pru_branch_eval #(.XLEN(XLEN)) u_eval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .branch_i   (exm_branch_i),
    .sense_ne_i (exm_br_ne_i),
    .alu_res_i  (exm_alu_res_i),
    .taken_o    (br_taken)
  );

  assign srcs = {ifid_rt_i, ifid_rs_i};

  pru_load_use #(.AW(AW), .NSRC(NSRC)) u_hazard (
    .mem_read_i (idex_mem_read_i),
    .load_rt_i  (idex_rt_i),
    .src_i      (srcs),
    .hazard_o   (hazard)
  );

  // a redirect discards the dependent fetch, so no stall is needed
  assign stall_o       = hazard & ~br_taken & ~idex_jump_i;
  assign idex_bubble_o = stall_o;
  assign ifid_flush_o  = br_taken;

  // jump is applied last, so it overrides a branch in the same cycle
  always_comb begin
    sel = PC_SEQ;
    if (stall_o)     sel = PC_HOLD;
    if (br_taken)    sel = PC_BRANCH;
    if (idex_jump_i) sel = PC_JUMP;
  end

  always_comb begin
    unique case (sel)
      PC_BRANCH: next_pc_o = exm_br_target_i;
      PC_JUMP:   next_pc_o = idex_jump_target_i;
      PC_HOLD:   next_pc_o = pc_i;
      default:   next_pc_o = pc_i + INSTR_BYTES;
    endcase
  end

  assign pc_sel_o = sel;

  pru_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stall_i       (stall_o),
    .flush_i       (ifid_flush_o),
    .cycle_cnt_o   (cycle_cnt_o),
    .retired_cnt_o (retired_cnt_o)
  );

  a_r6_jump_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_jump_i |-> (next_pc_o == idex_jump_target_i && pc_sel_o == 2'd2));

  a_r7_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (next_pc_o == pc_i && idex_bubble_o && !ifid_flush_o));

  a_r8_no_stall_on_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifid_flush_o || idex_jump_i) |-> !stall_o);

  a_r3_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o == 2'd0) |-> (next_pc_o == pc_i + INSTR_BYTES && !ifid_flush_o));
endmodule

// File: tb/pc_redirect_unit_bench.sv
`timescale 1ns/1ps
module pc_redirect_unit_bench;
  localparam int NRAND = 400;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc, alu, btgt, pc4, jtgt;
  logic [15:0] imm;
  logic        br, ne, jmp, mr;
  logic [4:0]  ex_rt, rs, rt;
  logic [31:0] br_target, next_pc, cyc, ret;
  logic [1:0]  sel;
  logic        flush, stall, bubble;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_cyc = 0;
  logic [31:0] exp_ret = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_redirect_unit u_pc_redirect_unit (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc),
    .exm_branch_i(br), .exm_br_ne_i(ne), .exm_alu_res_i(alu), .exm_br_target_i(btgt),
    .idex_pc4_i(pc4), .idex_imm_i(imm), .idex_jump_i(jmp), .idex_jump_target_i(jtgt),
    .idex_mem_read_i(mr), .idex_rt_i(ex_rt), .ifid_rs_i(rs), .ifid_rt_i(rt),
    .br_target_o(br_target), .next_pc_o(next_pc), .pc_sel_o(sel),
    .ifid_flush_o(flush), .stall_o(stall), .idex_bubble_o(bubble),
    .cycle_cnt_o(cyc), .retired_cnt_o(ret)
  );

  function automatic logic f_taken();
    return br & (ne ? (alu != 0) : (alu == 0));
  endfunction

  function automatic logic f_stall();
    return mr & ((rs == ex_rt) | (rt == ex_rt)) & ~f_taken() & ~jmp;
  endfunction

  function automatic logic [31:0] f_target();
    return pc4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  function automatic logic [31:0] f_next();
    if (jmp) return jtgt;
    if (f_taken()) return btgt;
    if (f_stall()) return pc;
    return pc + 32'd4;
  endfunction

  function automatic logic [1:0] f_sel();
    if (jmp) return 2'd2;
    if (f_taken()) return 2'd1;
    if (f_stall()) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string tag);
    logic e_stall, e_flush;
    #4;
    e_stall = f_stall();
    e_flush = f_taken();
    check(br_target == f_target(), {tag, " R4 target"}, br_target, f_target());
    check(next_pc == f_next(), {tag, " R1 R2 R3 R5 R6 R7 next_pc"}, next_pc, f_next());
    check(sel == f_sel(), {tag, " pc_sel"}, 32'(sel), 32'(f_sel()));
    check(flush == e_flush, {tag, " R1 R6 flush"}, 32'(flush), 32'(e_flush));
    check(stall == e_stall && bubble == e_stall, {tag, " R7 R8 stall/bubble"},
          {30'd0, stall, bubble}, {30'd0, e_stall, e_stall});
    @(posedge clk);
    #1;
    exp_cyc = exp_cyc + 1;
    if (!e_stall && !e_flush) exp_ret = exp_ret + 1;
    check(cyc == exp_cyc, {tag, " R9 cycles"}, cyc, exp_cyc);
    check(ret == exp_ret, {tag, " R10 retired"}, ret, exp_ret);
    @(negedge clk);
  endtask

  task automatic idle();
    pc = 32'h0040_0000; alu = 32'h1; btgt = 32'h0040_1000; pc4 = 32'h0040_0010;
    jtgt = 32'h0041_0000; imm = 16'h0004; br = 0; ne = 0; jmp = 0; mr = 0;
    ex_rt = 5'd9; rs = 5'd1; rt = 5'd2;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check(cyc == 0 && ret == 0, "R9 R10 reset counters", cyc, 0);
    rst_ni = 1'b1;
    #1;
    check(cyc == 0 && ret == 0, "R9 R10 after release", ret, 0);
    // R3 sequential
    apply("R3 seq");
    // R1 equal branch taken
    br = 1; alu = 0; apply("R1 beq taken");
    // R1 equal branch not taken on non-zero
    alu = 32'h8000_0000; apply("R3 beq not taken");
    // R2 ne taken, and not taken on zero
    ne = 1; apply("R2 bne taken");
    alu = 0; apply("R2 bne not taken");
    // R4 negative and wrapping immediates
    idle(); imm = 16'hFFFF; pc4 = 32'h0000_0000; apply("R4 wrap");
    imm = 16'h8000; pc4 = 32'h0002_0000; apply("R4 min");
    // R5 jump, no flush
    idle(); jmp = 1; apply("R5 jump");
    // R6 jump beats taken branch
    br = 1; alu = 0; apply("R6 jump over branch");
    // R7 load-use via rs, then via rt
    idle(); mr = 1; ex_rt = 5'd1; apply("R7 rs match");
    ex_rt = 5'd2; apply("R7 rt match");
    ex_rt = 5'd3; apply("R7 no match");
    // R8 load-use cancelled by branch and by jump
    ex_rt = 5'd1; br = 1; alu = 0; apply("R8 branch");
    br = 0; jmp = 1; apply("R8 jump");
    void'($urandom(32'd20240611));
    for (int i = 0; i < NRAND; i++) begin
      pc = $urandom; pc4 = $urandom; btgt = $urandom; jtgt = $urandom;
      imm = 16'($urandom);
      alu = ($urandom % 3 == 0) ? 32'd0 : $urandom;
      br = ($urandom % 3 == 0); ne = $urandom % 2;
      jmp = ($urandom % 5 == 0); mr = ($urandom % 2 == 0);
      ex_rt = 5'($urandom % 4); rs = 5'($urandom % 4); rt = 5'($urandom % 4);
      apply("rand");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule